// File: doc/BRIEF.md
# Bidirectional Word Rotator

This block rotates a data word by 0 to 7 positions in either direction. Bits pushed out at one end come back in at the other end. A single direction bit picks left or right, and a 3-bit amount sets how far the word moves. The block is purely combinational: the output follows the inputs with no clock and no stored state. It is meant to sit inside a larger datapath wherever a word must be turned in place.

The main datapath uses only one right-rotating log shifter, with three levels that move the word by 1, 2 and 4 positions. A left rotation reuses this shifter. A conditional bit-order mirror sits before the shifter and a second one sits after it, and both mirrors are enabled when the direction bit asks for left rotation.

A second datapath is built alongside the first. It has its own left rotator, its own right rotator and a 2-to-1 select driven by the direction bit. A parameter picks which datapath drives the output. The other datapath runs as a shadow, and an assertion requires the two to agree.

Top module: `bidir_rotator`

## Requirements
- R1: With `dir_left` = 0 and amount n, output bit i equals input bit (i+n) mod 8.
- R2: With `dir_left` = 1 and amount n, output bit (i+n) mod 8 equals input bit i.
- R3: Direction encoding is `dir_left` = 1 for left and `dir_left` = 0 for right. For example, input 8'h01 rotated by 3 gives 8'h08 to the left and 8'h20 to the right.
- R4: An amount of 0 returns the input word unchanged in both directions.
- R5: A one-position rotation gives {in[6:0], in[7]} to the left and {in[0], in[7:1]} to the right.
- R6: The mirrored single-shifter datapath (`USE_MIRROR` = 1) and the separate-rotators-plus-select datapath (`USE_MIRROR` = 0) give identical outputs for every data, amount and direction.
- R7: The output is a combinational function of the inputs. It settles after an input change with no clock edge in between.
- R8: The number of set bits in the output always equals the number in the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Word to rotate |
| dir_left | input | 1 | 1 = rotate left, 0 = rotate right |
| amt | input | 3 | Rotate distance, 0 to 7 positions |
| dout | output | 8 | Rotated word |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between any input and `dout`. The bench applies each input combination just after a rising edge and compares the output at the following falling edge, half a period later. No edge falls between the input change and the sample, so the design can hold no state that the check would miss. The combinational claim is also checked with no clock edge at all: an input is changed between edges and `dout` is read one nanosecond later.

// File: rtl/rot_pkg.sv
package rot_pkg;

    localparam int unsigned ROT_W = 8;
    localparam int unsigned ROT_AMT_W = $clog2(ROT_W);

    typedef enum logic {
        DIR_RIGHT = 1'b0,
        DIR_LEFT  = 1'b1
    } rot_dir_e;

    typedef struct packed {
        logic [ROT_W-1:0]     word;
        logic [ROT_AMT_W-1:0] amt;
        rot_dir_e             dir;
    } rot_req_t;

    // Number of set bits in a default-width word.
    function automatic int unsigned ones_of(input logic [ROT_W-1:0] w);
        int unsigned c;
        c = 0;
        for (int i = 0; i < ROT_W; i++) begin
            c += int'(w[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/rot_mirror.sv
// Conditional bit-order reversal: passes the word through, or maps bit i to bit WIDTH-1-i.
module rot_mirror #(
    parameter int unsigned WIDTH = rot_pkg::ROT_W
) (
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = en ? din[WIDTH-1-i] : din[i];
    end
endmodule

// File: rtl/rot_log_core.sv
// Log-structured rotator: level k turns the word by 2**k when amt[k] is set.
// TO_LEFT picks the direction of the hard-wired level permutations.
module rot_log_core #(
    parameter int unsigned WIDTH   = rot_pkg::ROT_W,
    parameter bit          TO_LEFT = 1'b0,
    localparam int unsigned AMT_W  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] lvl [0:AMT_W];

    assign lvl[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_lvl
        localparam int unsigned SH = 1 << k;
        logic [WIDTH-1:0] turned;
        if (TO_LEFT) begin : g_left
            assign turned = {lvl[k][WIDTH-SH-1:0], lvl[k][WIDTH-1:WIDTH-SH]};
        end else begin : g_right
            assign turned = {lvl[k][SH-1:0], lvl[k][WIDTH-1:SH]};
        end
        assign lvl[k+1] = amt[k] ? turned : lvl[k];
    end

    assign dout = lvl[AMT_W];
endmodule

// File: rtl/rot_path_mirror.sv
// Single right-rotating core wrapped by two conditional mirrors.
module rot_path_mirror #(
    parameter int unsigned WIDTH  = rot_pkg::ROT_W,
    localparam int unsigned AMT_W = $clog2(WIDTH)
) (
    input  rot_pkg::rot_dir_e dir,
    input  logic [WIDTH-1:0]  din,
    input  logic [AMT_W-1:0]  amt,
    output logic [WIDTH-1:0]  dout
);
    logic             flip;
    logic [WIDTH-1:0] pre_w;
    logic [WIDTH-1:0] core_w;

    assign flip = (dir == rot_pkg::DIR_LEFT);

    rot_mirror #(.WIDTH(WIDTH)) u_pre (
        .en(flip), .din(din), .dout(pre_w)
    );

    rot_log_core #(.WIDTH(WIDTH), .TO_LEFT(1'b0)) u_core (
        .din(pre_w), .amt(amt), .dout(core_w)
    );

    rot_mirror #(.WIDTH(WIDTH)) u_post (
        .en(flip), .din(core_w), .dout(dout)
    );
endmodule

// File: rtl/rot_path_select.sv
// Separate left and right cores feeding a 2-to-1 select.
module rot_path_select #(
    parameter int unsigned WIDTH  = rot_pkg::ROT_W,
    localparam int unsigned AMT_W = $clog2(WIDTH)
) (
    input  rot_pkg::rot_dir_e dir,
    input  logic [WIDTH-1:0]  din,
    input  logic [AMT_W-1:0]  amt,
    output logic [WIDTH-1:0]  dout
);
    logic [WIDTH-1:0] left_w;
    logic [WIDTH-1:0] right_w;

    rot_log_core #(.WIDTH(WIDTH), .TO_LEFT(1'b1)) u_left (
        .din(din), .amt(amt), .dout(left_w)
    );

    rot_log_core #(.WIDTH(WIDTH), .TO_LEFT(1'b0)) u_right (
        .din(din), .amt(amt), .dout(right_w)
    );

    always_comb begin
        unique case (dir)
            rot_pkg::DIR_LEFT:  dout = left_w;
            default:            dout = right_w;
        endcase
    end
endmodule

// File: rtl/bidir_rotator.sv
module bidir_rotator #(
    parameter int unsigned WIDTH      = rot_pkg::ROT_W,
    parameter bit          USE_MIRROR = 1'b1,
    localparam int unsigned AMT_W     = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic             dir_left,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] dout
);
    rot_pkg::rot_dir_e dir;
    logic [WIDTH-1:0]  res_mirror;
    logic [WIDTH-1:0]  res_select;

    assign dir = dir_left ? rot_pkg::DIR_LEFT : rot_pkg::DIR_RIGHT;

    rot_path_mirror #(.WIDTH(WIDTH)) u_mirror (
        .dir(dir), .din(din), .amt(amt), .dout(res_mirror)
    );

    rot_path_select #(.WIDTH(WIDTH)) u_select (
        .dir(dir), .din(din), .amt(amt), .dout(res_select)
    );

    if (USE_MIRROR) begin : g_out_mirror
        assign dout = res_mirror;
    end else begin : g_out_select
        assign dout = res_select;
    end

    always_comb begin
        AST_PATHS_AGREE: assert (res_mirror == res_select) else $error("datapaths disagree"); // R6
        if (amt == '0) begin
            AST_ZERO_PASS: assert (dout == din) else $error("zero amount altered word"); // R4
        end
        if (amt == AMT_W'(1) && dir_left) begin
            AST_STEP_LEFT: assert (dout == {din[WIDTH-2:0], din[WIDTH-1]}) else $error("left step"); // R5
        end
        if (amt == AMT_W'(1) && !dir_left) begin
            AST_STEP_RIGHT: assert (dout == {din[0], din[WIDTH-1:1]}) else $error("right step"); // R5
        end
        AST_ONES_KEPT: assert ($countones(dout) == $countones(din)) else $error("bit count changed"); // R8
    end
endmodule

// File: tb/bidir_rotator_test.sv
module bidir_rotator_test;
    localparam int W  = 8;
    localparam int AW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [W-1:0]  din      = '0;
    logic          dir_left = 1'b0;
    logic [AW-1:0] amt      = '0;
    logic [W-1:0]  dout;
    logic [W-1:0]  dout_sel;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    bidir_rotator #(.WIDTH(W), .USE_MIRROR(1'b1)) uut (
        .din(din), .dir_left(dir_left), .amt(amt), .dout(dout)
    );

    bidir_rotator #(.WIDTH(W), .USE_MIRROR(1'b0)) uut_sel (
        .din(din), .dir_left(dir_left), .amt(amt), .dout(dout_sel)
    );

    function automatic logic [7:0] model(int d, int n, bit left);
        int r;
        if (left) r = (d << n) | (d >> (8 - n));
        else      r = (d >> n) | (d << (8 - n));
        return 8'(r & 255);
    endfunction

    function automatic int ones(int d);
        int c = 0;
        for (int i = 0; i < 8; i++) c += (d >> i) & 1;
        return c;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h (din=%0h dir_left=%0d amt=%0d)",
                     tag, act, exp, din, dir_left, amt);
        end
    endtask

    task automatic apply(int d, bit left, int n);
        @(posedge clk);
        din      <= 8'(d);
        dir_left <= left;
        amt      <= 3'(n);
        @(negedge clk);
    endtask

    initial begin
        #1;
        check("R7 idle output", int'(dout), 0);
        din = 8'hA5;
        #1;
        check("R7 no-clock settle", int'(dout), 'hA5);
        amt = 3'd2;
        #1;
        check("R7 no-clock settle", int'(dout), int'(model('hA5, 2, 1'b0)));

        apply('h01, 1'b1, 3);
        check("R3 left encoding", int'(dout), 'h08);
        apply('h01, 1'b0, 3);
        check("R3 right encoding", int'(dout), 'h20);
        apply('h81, 1'b1, 1);
        check("R5 left step", int'(dout), 'h03);
        apply('h81, 1'b0, 1);
        check("R5 right step", int'(dout), 'hC0);
        apply('h3C, 1'b1, 0);
        check("R4 zero left", int'(dout), 'h3C);
        apply('h3C, 1'b0, 0);
        check("R4 zero right", int'(dout), 'h3C);

        for (int dl = 0; dl < 2; dl++) begin
            for (int n = 0; n < 8; n++) begin
                for (int d = 0; d < 256; d++) begin
                    string tag;
                    int    exp;
                    apply(d, bit'(dl), n);
                    exp = int'(model(d, n, bit'(dl)));
                    if (n == 0)       tag = "R4 zero amount";
                    else if (n == 1)  tag = "R5 single step";
                    else if (dl == 1) tag = "R2 left rotate";
                    else              tag = "R1 right rotate";
                    check(tag, int'(dout), exp);
                    check("R6 datapaths match", int'(dout_sel), exp);
                    check("R8 ones count", ones(int'(dout)), ones(d));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule